// File: doc/BRIEF.md
# Paged Circular-Buffer Address Generator

This block produces 24-bit data addresses for a processor datapath. It holds four 16-bit index pointers. Each pointer has its own base and length registers. Four modify registers are shared, so any pointer can use any of them. A separate 8-bit page register supplies the upper byte of every address, so the index arithmetic never has to carry into the page.

Each command names one pointer, an operation, and a modify source. The modify source is either one of the four modify registers or an 8-bit signed immediate. Three operations are available:

- **Post-modify** emits the current index and then writes back the stepped value.
- **Pre-modify** emits the stepped value and leaves the pointer unchanged.
- **Modify-only** steps the pointer without emitting an address.

When a pointer's length is nonzero, stepping is modulo inside the window `[base, base+length)`. The base may take any value. Because wrapping acts on the 16-bit index only, a buffer can never leave its 64K-word page.

Software loads the registers through a single write port. A command issued in the same cycle as a write sees the register values from before that write.

Top module: `paged_circ_agu`

## Requirements
- R1: After reset, `addr_valid` is 0 and `addr_out` is 0. All index, modify, length, base and page registers are 0, so a post-modify issued right after reset returns address 0.
- R2: Every emitted address is {page register, 16-bit effective index}, with the page in bits 23:16. The page register is loaded by a write with `wr_sel`=4 (low 8 bits of `wr_data`), and commands never alter it.
- R3: A post-modify (`cmd_op`=1) emits the pointer's current index. The pointer then holds index + modify, with wrap applied.
- R4: A pre-modify (`cmd_op`=2) emits index + modify, with wrap applied, and leaves the pointer unchanged.
- R5: When `cmd_use_imm` is 1, `cmd_imm` is sign-extended to 16 bits and used in place of the selected modify register. This holds for post-modify, pre-modify and modify-only.
- R6: A modify-only command (`cmd_op`=3) updates the pointer exactly as a post-modify would, but produces no address: `addr_valid` stays 0.
- R7: With a nonzero length, the stepped index wraps into `[base, base+length)`. A result at or above base+length has length subtracted; a result below base has length added. This is valid for |modify| < length and for any base whose window ends at or below 0x10000.
- R8: With length 0, stepping is plain 16-bit addition modulo 2^16.
- R9: `addr_valid` is 1 exactly in the cycle after an accepted post-modify or pre-modify. It is 0 after a NOP (`cmd_op`=0), after a modify-only, and when `cmd_valid` is 0. The address is registered and appears one cycle after the command.
- R10: A command and a register write in the same cycle resolve as follows. The command uses the register values from before the write. If the write targets the same pointer's index (`wr_sel`=0) that the command updates, the written value wins. The other `wr_sel` codes are 1 for modify, 2 for length and 3 for base, each selected by `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 NOP, 1 post-modify, 2 pre-modify, 3 modify-only |
| cmd_ptr | input | 2 | Pointer select |
| cmd_msel | input | 2 | Modify register select |
| cmd_use_imm | input | 1 | Use the immediate instead of a modify register |
| cmd_imm | input | 8 | Signed immediate modify |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 index, 1 modify, 2 length, 3 base, 4 page |
| wr_idx | input | 2 | Register number for index/modify/length/base |
| wr_data | input | 16 | Write data (page uses bits 7:0) |
| addr_out | output | 24 | Generated address |
| addr_valid | output | 1 | Address strobe |

## Verification
The window-containment property assumes two things about the inputs: the selected pointer already lies inside its window, and the magnitude of the chosen modify value is below the window length. The random stimulus respects both.

- Every circular window is at least 200 words long.
- Every modify register is kept within ±127, and immediates are at most 128 in magnitude.
- Index, base and length are only rewritten during configuration, which places each index inside its window.
- One pointer is left non-circular so that 16-bit wrap-around runs freely.

The remaining properties make no assumption beyond a clean reset.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_POST = 2'd1,
    OP_PRE  = 2'd2,
    OP_MOD  = 2'd3
  } agu_op_e;

  typedef enum logic [2:0] {
    WT_INDEX  = 3'd0,
    WT_MODIFY = 3'd1,
    WT_LENGTH = 3'd2,
    WT_BASE   = 3'd3,
    WT_PAGE   = 3'd4
  } agu_wtarget_e;

  function automatic logic op_emits(input logic [1:0] op);
    return (op == OP_POST) || (op == OP_PRE);
  endfunction

  function automatic logic op_updates(input logic [1:0] op);
    return (op == OP_POST) || (op == OP_MOD);
  endfunction

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int NUM_PTR = 4,
  parameter int IDX_W   = 16,
  parameter int PAGE_W  = 8,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_data,
  input  logic              upd_we,
  input  logic [SEL_W-1:0]  upd_ptr,
  input  logic [IDX_W-1:0]  upd_val,
  input  logic [SEL_W-1:0]  rd_ptr,
  input  logic [SEL_W-1:0]  rd_msel,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [IDX_W-1:0]  rd_len,
  output logic [IDX_W-1:0]  rd_mod,
  output logic [PAGE_W-1:0] page_q
);
  import agu_pkg::*;

  logic [IDX_W-1:0] idx_q  [NUM_PTR];
  logic [IDX_W-1:0] mod_q  [NUM_PTR];
  logic [IDX_W-1:0] len_q  [NUM_PTR];
  logic [IDX_W-1:0] base_q [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic hit;
    assign hit = wr_en && (wr_idx == SEL_W'(g));

    // an explicit index write overrides the command update (R10)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[g] <= '0;
      end else if (hit && (wr_sel == WT_INDEX)) begin
        idx_q[g] <= wr_data;
      end else if (upd_we && (upd_ptr == SEL_W'(g))) begin
        idx_q[g] <= upd_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mod_q[g]  <= '0;
        len_q[g]  <= '0;
        base_q[g] <= '0;
      end else if (hit) begin
        if (wr_sel == WT_MODIFY) mod_q[g]  <= wr_data;
        if (wr_sel == WT_LENGTH) len_q[g]  <= wr_data;
        if (wr_sel == WT_BASE)   base_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (wr_en && (wr_sel == WT_PAGE)) begin
      page_q <= wr_data[PAGE_W-1:0];
    end
  end

  assign rd_idx  = idx_q[rd_ptr];
  assign rd_base = base_q[rd_ptr];
  assign rd_len  = len_q[rd_ptr];
  assign rd_mod  = mod_q[rd_msel];

endmodule

// File: rtl/agu_step.sv
module agu_step #(
  parameter int IDX_W = 16,
  parameter int IMM_W = 8
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] cur_base,
  input  logic [IDX_W-1:0] cur_len,
  input  logic [IDX_W-1:0] reg_mod,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  output logic [IDX_W-1:0] step_mod,
  output logic [IDX_W-1:0] next_idx
);
  localparam int EXT_W = IDX_W + 2;

  function automatic logic [IDX_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(IDX_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  // modulo step in a window; a zero length gives plain 2^IDX_W wrap
  function automatic logic [IDX_W-1:0] circ_add(
    input logic [IDX_W-1:0] idx,
    input logic [IDX_W-1:0] m,
    input logic [IDX_W-1:0] b,
    input logic [IDX_W-1:0] l
  );
    logic signed [EXT_W-1:0] raw, lo, hi, span;
    raw  = $signed({2'b00, idx}) + $signed({{2{m[IDX_W-1]}}, m});
    lo   = $signed({2'b00, b});
    span = $signed({2'b00, l});
    hi   = lo + span;
    if (l != '0) begin
      if (raw >= hi) begin
        raw = raw - span;
      end else if (raw < lo) begin
        raw = raw + span;
      end
    end
    return raw[IDX_W-1:0];
  endfunction

  assign step_mod = use_imm ? sext_imm(imm) : reg_mod;
  assign next_idx = circ_add(cur_idx, step_mod, cur_base, cur_len);

endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic              valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit;
      if (emit) addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/paged_circ_agu.sv
module paged_circ_agu #(
  parameter int NUM_PTR = 4,
  parameter int IDX_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int IMM_W   = 8,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SEL_W-1:0]  cmd_ptr,
  input  logic [SEL_W-1:0]  cmd_msel,
  input  logic              cmd_use_imm,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_data,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  import agu_pkg::*;

  // named internal events for the checker
  logic              emit;
  logic              upd_we;
  logic [IDX_W-1:0]  cur_idx;
  logic [IDX_W-1:0]  cur_base;
  logic [IDX_W-1:0]  cur_len;
  logic [IDX_W-1:0]  reg_mod;
  logic [IDX_W-1:0]  step_mod;
  logic [IDX_W-1:0]  next_idx;
  logic [IDX_W-1:0]  eff_idx;
  logic [PAGE_W-1:0] page_q;

  assign emit    = cmd_valid && op_emits(cmd_op);
  assign upd_we  = cmd_valid && op_updates(cmd_op);
  assign eff_idx = (cmd_op == OP_PRE) ? next_idx : cur_idx;

  agu_regfile #(
    .NUM_PTR(NUM_PTR), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .upd_we(upd_we), .upd_ptr(cmd_ptr), .upd_val(next_idx),
    .rd_ptr(cmd_ptr), .rd_msel(cmd_msel),
    .rd_idx(cur_idx), .rd_base(cur_base), .rd_len(cur_len), .rd_mod(reg_mod),
    .page_q(page_q)
  );

  agu_step #(.IDX_W(IDX_W), .IMM_W(IMM_W)) i_step (
    .cur_idx(cur_idx), .cur_base(cur_base), .cur_len(cur_len),
    .reg_mod(reg_mod), .use_imm(cmd_use_imm), .imm(cmd_imm),
    .step_mod(step_mod), .next_idx(next_idx)
  );

  agu_outreg #(.ADDR_W(ADDR_W)) i_out (
    .clk(clk), .rst_n(rst_n), .emit(emit),
    .addr_d({page_q, eff_idx}),
    .addr_q(addr_out), .valid_q(addr_valid)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int IDX_W  = 16,
  parameter int PAGE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [1:0]              cmd_op,
  input logic                    addr_valid,
  input logic [PAGE_W+IDX_W-1:0] addr_out,
  input logic [PAGE_W-1:0]       page_q,
  input logic                    upd_we,
  input logic [IDX_W-1:0]        cur_idx,
  input logic [IDX_W-1:0]        cur_base,
  input logic [IDX_W-1:0]        cur_len,
  input logic [IDX_W-1:0]        next_idx
);
  logic acc_cmd, post_cmd, pre_cmd, in_win, next_in_win;
  assign acc_cmd  = cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2);
  assign post_cmd = cmd_valid && (cmd_op == 2'd1);
  assign pre_cmd  = cmd_valid && (cmd_op == 2'd2);
  assign in_win   = ({1'b0, cur_idx} >= {1'b0, cur_base}) &&
                    ({1'b0, cur_idx} <  ({1'b0, cur_base} + {1'b0, cur_len}));
  assign next_in_win = ({1'b0, next_idx} >= {1'b0, cur_base}) &&
                       ({1'b0, next_idx} <  ({1'b0, cur_base} + {1'b0, cur_len}));

  // R9
  access_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cmd |=> addr_valid);

  // R9
  quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_cmd |=> !addr_valid);

  // R4
  pre_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cmd |-> !upd_we);

  // R2
  page_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cmd |=> addr_out[PAGE_W+IDX_W-1:IDX_W] == $past(page_q));

  // R3
  post_emits_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_cmd |=> addr_out[IDX_W-1:0] == $past(cur_idx));

  // R7
  circ_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && cur_len != '0 && in_win) |-> next_in_win);

endmodule

bind paged_circ_agu agu_checker #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .addr_valid(addr_valid), .addr_out(addr_out), .page_q(page_q),
  .upd_we(upd_we), .cur_idx(cur_idx), .cur_base(cur_base),
  .cur_len(cur_len), .next_idx(next_idx)
);

// File: tb/test_paged_circ_agu.sv
module test_paged_circ_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [1:0]  cmd_ptr = 0;
  logic [1:0]  cmd_msel = 0;
  logic        cmd_use_imm = 0;
  logic [7:0]  cmd_imm = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = 0;
  logic [1:0]  wr_idx = 0;
  logic [15:0] wr_data = 0;
  logic [23:0] addr_out;
  logic        addr_valid;

  int n_chk = 0, n_bad = 0;
  int m_idx[4], m_mod[4], m_len[4], m_base[4], m_page;

  always #5 clk = ~clk;

  paged_circ_agu i_paged_circ_agu (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ptr(cmd_ptr), .cmd_msel(cmd_msel), .cmd_use_imm(cmd_use_imm),
    .cmd_imm(cmd_imm), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int sx16(int v);
    v = v & 16'hFFFF;
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic int model_step(int idx, int m, int b, int l);
    int s = idx + m;
    if (l != 0) begin
      if (s >= b + l) s = s - l;
      else if (s < b) s = s + l;
    end
    return s & 16'hFFFF;
  endfunction

  // one cycle: drive after a falling edge, check at the next falling edge
  task automatic step(string req, bit cv, int op, int p, int ms, bit ui, int imm,
                      bit we, int ws, int wi, int wd);
    int mv, nxt, exp_a;
    bit acc;
    cmd_valid = cv; cmd_op = 2'(op); cmd_ptr = 2'(p); cmd_msel = 2'(ms);
    cmd_use_imm = ui; cmd_imm = 8'(imm);
    wr_en = we; wr_sel = 3'(ws); wr_idx = 2'(wi); wr_data = 16'(wd);
    mv  = ui ? ((imm & 8'hFF) >= 128 ? (imm & 8'hFF) - 256 : (imm & 8'hFF))
             : sx16(m_mod[ms]);
    nxt = model_step(m_idx[p], mv, m_base[p], m_len[p]);
    acc = cv && (op == 1 || op == 2);
    exp_a = (m_page << 16) | ((op == 2) ? nxt : m_idx[p]);
    if (cv && (op == 1 || op == 3)) m_idx[p] = nxt;
    if (we) begin
      case (ws)
        0: m_idx[wi]  = wd & 16'hFFFF;
        1: m_mod[wi]  = wd & 16'hFFFF;
        2: m_len[wi]  = wd & 16'hFFFF;
        3: m_base[wi] = wd & 16'hFFFF;
        default: m_page = wd & 8'hFF;
      endcase
    end
    @(negedge clk);
    cmd_valid = 0; wr_en = 0;
    check({req, " R9 strobe"}, int'(addr_valid), int'(acc));
    if (acc) check(req, int'(addr_out), exp_a);
  endtask

  task automatic wr(int ws, int wi, int wd);
    step("R10 write", 0, 0, 0, 0, 0, 0, 1, ws, wi, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    for (int i = 0; i < 4; i++) begin
      m_idx[i] = 0; m_mod[i] = 0; m_len[i] = 0; m_base[i] = 0;
    end
    m_page = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(addr_valid), 0);
    check("R1 reset addr", int'(addr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1 zero regs", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2 page and R7 upward wrap at the page top
    wr(4, 0, 16'h005A);
    wr(3, 0, 16'hFF00); wr(2, 0, 16'h0100); wr(0, 0, 16'hFFFE); wr(1, 0, 1);
    step("R2 R3 post", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 post at top", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 wrapped to base", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R4/R5/R7 downward wrap via negative immediate
    wr(3, 1, 16'h1000); wr(2, 1, 16'h0200); wr(0, 1, 16'h1000);
    step("R4 R5 R7 pre imm -1", 1, 2, 1, 0, 1, 8'hFF, 0, 0, 0, 0);
    step("R4 ptr unchanged", 1, 1, 1, 0, 1, 0, 0, 0, 0, 0);

    // R6/R8 linear wrap-around with modify-only
    wr(0, 2, 16'hFFFF);
    step("R6 R8 modify-only", 1, 3, 2, 0, 1, 2, 0, 0, 0, 0);
    step("R8 wrapped 16-bit", 1, 1, 2, 0, 1, 0, 0, 0, 0, 0);
    step("R5 imm -128", 1, 2, 2, 0, 1, 8'h80, 0, 0, 0, 0);

    // R10 same-cycle writes
    step("R10 old modify", 1, 1, 2, 1, 0, 0, 1, 1, 1, 5);
    step("R10 new modify", 1, 1, 2, 1, 0, 0, 0, 0, 0, 0);
    step("R10 index write wins", 1, 1, 2, 0, 1, 3, 1, 0, 2, 16'h4444);
    step("R10 index read back", 1, 1, 2, 0, 1, 0, 0, 0, 0, 0);
    step("R10 old page", 1, 2, 2, 0, 1, 0, 1, 4, 0, 16'h00C3);
    step("R2 new page", 1, 2, 2, 0, 1, 0, 0, 0, 0, 0);
    step("R9 nop", 1, 0, 2, 0, 0, 0, 0, 0, 0, 0);
    step("R9 idle", 0, 1, 2, 0, 0, 0, 0, 0, 0, 0);

    // random configuration: three circular pointers, one linear
    for (int p = 0; p < 3; p++) begin
      int l = 200 + ($urandom % 3897);
      int b = $urandom % (65536 - l + 1);
      wr(2, p, 0); wr(3, p, b); wr(0, p, b + ($urandom % l)); wr(2, p, l);
    end
    wr(2, 3, 0); wr(0, 3, $urandom % 65536);
    for (int m = 0; m < 4; m++) wr(1, m, (int'($urandom % 255) - 127) & 16'hFFFF);

    for (int k = 0; k < 3000; k++) begin
      int op = $urandom % 4;
      int p  = $urandom % 4;
      bit we = ($urandom % 8) == 0;
      bit pg = ($urandom % 2) == 0;
      string tag = (op == 1) ? "R3 R7 rand post" : (op == 2) ? "R4 R5 rand pre" :
                   (op == 3) ? "R6 rand modify" : "R9 rand nop";
      step(tag, ($urandom % 6) != 0, op, p, $urandom % 4, $urandom % 2, $urandom % 256,
           we, pg ? 4 : 1, $urandom % 4,
           pg ? ($urandom % 256) : ((int'($urandom % 255) - 127) & 16'hFFFF));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule